// File: doc/BRIEF.md
# Serial LED Dot-Matrix Receiver

This block is the receiving side of a serially loaded LED character display. A host clocks one data bit per rising edge of a serial clock into one of two targets, while an active-low load strobe is held low. A select input picks the target. With the select low, the bits go into a 160-stage pixel chain. With the select high, they go into an 8-stage configuration shifter. The last stage of the pixel chain is brought out as a serial output, so that two or more receivers can be chained into one longer pixel stream.

Nothing the host shifts in becomes visible right away. After the strobe returns high, the next falling clock edge commits the frame. A pixel frame is copied into a display latch. A configuration frame is written into one of two 7-bit configuration words, chosen by the first bit shifted. The display latch drives the pixel outputs. These are gated to zero whenever the wake bit of configuration word 0 is clear.

Reset clears the configuration side and so puts the display to sleep. It leaves the pixel chain and the display latch untouched. Waking the display after a reset shows the last committed pattern again.

Top module: `dmx_serial_rx`

## Requirements
- R1: Pixel output bit i equals display latch bit i while awake; a 1 lights the LED and a 0 darkens it, over all 160 positions.
- R2: With the load strobe low and the select low, each rising clock edge moves every pixel chain bit up one stage and places the serial input in stage 0, so the first bit of a 160-bit frame lands in position 159.
- R3: The display latch copies the pixel chain at the first falling edge at which the strobe is high, following a falling edge at which it was low; until then the pixel outputs stay unchanged, including while a new frame is being shifted in.
- R4: With the load strobe low and the select high, each rising edge shifts the serial input into stage 0 of an 8-stage configuration shifter, so after any frame the last 8 bits shifted remain, the earliest of them in bit 7.
- R5: At the commit of a configuration frame, a shifter bit 7 of 1 writes shifter bits 6..0 into configuration word 1 and a 0 writes them into configuration word 0; the other word keeps its value.
- R6: Reset (active low) clears both configuration words and the configuration shifter, which forces sleep and blanks the pixel outputs; the pixel chain and the display latch keep their contents through reset.
- R7: The serial output equals pixel chain stage 159, so a bit entering the chain appears at the serial output after 160 shifting edges.
- R8: The sleep output equals the inverse of configuration word 0 bit 6, and all pixel outputs read 0 while it is high.
- R9: A pixel frame leaves both configuration words unchanged, and a configuration frame leaves the pixel chain unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; rising edge shifts, falling edge commits |
| rst_n | input | 1 | Asynchronous active-low reset of the configuration side |
| ser_in | input | 1 | Serial data input |
| load_n | input | 1 | Active-low load strobe framing a transfer |
| ctl_sel | input | 1 | Target select: 0 pixel chain, 1 configuration shifter |
| ser_out | output | 1 | Last pixel chain stage, for chaining receivers |
| pix | output | 160 | Displayed pixel pattern, gated by the wake bit |
| asleep | output | 1 | High while configuration word 0 bit 6 is clear |
| cfg0 | output | 7 | Configuration word 0 (bit 6 wake, low bits brightness code) |
| cfg1 | output | 7 | Configuration word 1 |

## Verification
The clocked properties assume that the strobe, the select and the serial input are steady around both clock edges. They also assume that reset is asserted only while the strobe is high, so that no half-shifted frame meets a reset. The stimulus changes every input two nanoseconds after a falling edge, which keeps each input steady through the following rising and falling edges. It pulses reset only between frames. The bench samples results one nanosecond after a rising edge, or two nanoseconds after a falling edge, so that each value is read after the register that drives it has updated.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
    // Which target the most recent shifting edge wrote into.
    typedef enum logic {
        FR_DOT = 1'b0,
        FR_CTL = 1'b1
    } frame_kind_t;
endpackage

// File: rtl/dmx_commit.sv
// Produces the commit strobes: true during the falling edge at which the
// load strobe is high after having been low at the previous falling edge.
module dmx_commit
    import dmx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_n,
    input  logic ctl_sel,
    output logic commit_dot,
    output logic commit_ctl
);
    frame_kind_t kind_d, kind_q;
    logic        low_seen_d, low_seen_q;
    logic        fire;

    always_comb begin
        kind_d = kind_q;
        if (!load_n) begin
            kind_d = ctl_sel ? FR_CTL : FR_DOT;
        end
        low_seen_d = !load_n;
    end

    // Rising domain: remember which target the frame went to.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) kind_q <= FR_DOT;
        else        kind_q <= kind_d;
    end

    // Falling domain: remember whether the strobe was low last time.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) low_seen_q <= 1'b0;
        else        low_seen_q <= low_seen_d;
    end

    assign fire       = load_n && low_seen_q;
    assign commit_dot = fire && (kind_q == FR_DOT);
    assign commit_ctl = fire && (kind_q == FR_CTL);
endmodule

// File: rtl/dmx_dot_store.sv
// Pixel chain (rising edge) and display latch (falling edge). Neither is reset.
module dmx_dot_store #(
    parameter int NDOT = 160
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift_en,
    input  logic            ser_in,
    input  logic            commit,
    output logic            chain_msb,
    output logic [NDOT-1:0] latch
);
    typedef struct packed {
        logic [NDOT-1:0] chain;
    } rise_st_t;

    typedef struct packed {
        logic [NDOT-1:0] shown;
    } fall_st_t;

    rise_st_t rise_d, rise_q;
    fall_st_t fall_d, fall_q;

    always_comb begin
        rise_d = rise_q;
        fall_d = fall_q;
        if (shift_en) begin
            rise_d.chain = {rise_q.chain[NDOT-2:0], ser_in};
        end
        if (commit) begin
            fall_d.shown = rise_q.chain;
        end
    end

    always_ff @(posedge clk) begin
        rise_q <= rise_d;
    end

    always_ff @(negedge clk) begin
        fall_q <= fall_d;
    end

    assign chain_msb = rise_q.chain[NDOT-1];
    assign latch     = fall_q.shown;

    // R2: serial input enters stage 0, older bits move one stage up
    a_r2_chain_shift: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (rise_q.chain[0] == $past(ser_in))
                  && (rise_q.chain[NDOT-1:1] == $past(rise_q.chain[NDOT-2:0])));

    // R9: no shifting edge, no change in the pixel chain
    a_r9_chain_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(rise_q.chain));
endmodule

// File: rtl/dmx_ctrl_store.sv
// Configuration shifter (rising edge) and the two configuration words
// (falling edge, written at commit).
module dmx_ctrl_store #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_en,
    input  logic          ser_in,
    input  logic          commit,
    output logic [CW-1:0] word0,
    output logic [CW-1:0] word1
);
    localparam int SRW = CW + 1;

    typedef struct packed {
        logic [SRW-1:0] sr;
    } rise_st_t;

    typedef struct packed {
        logic [CW-1:0] w0;
        logic [CW-1:0] w1;
    } fall_st_t;

    rise_st_t rise_d, rise_q;
    fall_st_t fall_d, fall_q;

    always_comb begin
        rise_d = rise_q;
        fall_d = fall_q;
        if (shift_en) begin
            rise_d.sr = {rise_q.sr[SRW-2:0], ser_in};
        end
        if (commit) begin
            if (rise_q.sr[SRW-1]) fall_d.w1 = rise_q.sr[CW-1:0];
            else                  fall_d.w0 = rise_q.sr[CW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rise_q <= '0;
        else        rise_q <= rise_d;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fall_q <= '0;
        else        fall_q <= fall_d;
    end

    assign word0 = fall_q.w0;
    assign word1 = fall_q.w1;

    // R4: configuration shifter takes the serial bit in stage 0
    a_r4_cfg_shift: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (rise_q.sr[0] == $past(ser_in))
                  && (rise_q.sr[SRW-1:1] == $past(rise_q.sr[SRW-2:0])));

    // R5: the word that bit 7 does not select keeps its value
    a_r5_keep_w0: assert property (@(negedge clk) disable iff (!rst_n)
        (commit && rise_q.sr[SRW-1]) |=> $stable(fall_q.w0));
    a_r5_keep_w1: assert property (@(negedge clk) disable iff (!rst_n)
        (commit && !rise_q.sr[SRW-1]) |=> $stable(fall_q.w1));

    // R6: while reset is held, the configuration side reads zero
    a_r6_reset_clear: assert property (@(posedge clk)
        !rst_n |-> (fall_q.w0 == '0) && (fall_q.w1 == '0) && (rise_q.sr == '0));
endmodule

// File: rtl/dmx_serial_rx.sv
module dmx_serial_rx
    import dmx_pkg::*;
#(
    parameter int NDOT      = 160,
    parameter int CW        = 7,
    parameter int AWAKE_BIT = 6
) (
    input  logic            sclk,
    input  logic            rst_n,
    input  logic            ser_in,
    input  logic            load_n,
    input  logic            ctl_sel,
    output logic            ser_out,
    output logic [NDOT-1:0] pix,
    output logic            asleep,
    output logic [CW-1:0]   cfg0,
    output logic [CW-1:0]   cfg1
);
    logic            shift_dot, shift_ctl;
    logic            commit_dot, commit_ctl;
    logic [NDOT-1:0] latch;
    logic            awake;

    assign shift_dot = !load_n && !ctl_sel;
    assign shift_ctl = !load_n &&  ctl_sel;

    dmx_commit u_commit (
        .clk        (sclk),
        .rst_n      (rst_n),
        .load_n     (load_n),
        .ctl_sel    (ctl_sel),
        .commit_dot (commit_dot),
        .commit_ctl (commit_ctl)
    );

    dmx_dot_store #(.NDOT(NDOT)) u_dots (
        .clk       (sclk),
        .rst_n     (rst_n),
        .shift_en  (shift_dot),
        .ser_in    (ser_in),
        .commit    (commit_dot),
        .chain_msb (ser_out),
        .latch     (latch)
    );

    dmx_ctrl_store #(.CW(CW)) u_ctrl (
        .clk      (sclk),
        .rst_n    (rst_n),
        .shift_en (shift_ctl),
        .ser_in   (ser_in),
        .commit   (commit_ctl),
        .word0    (cfg0),
        .word1    (cfg1)
    );

    assign awake  = cfg0[AWAKE_BIT];
    assign asleep = !awake;
    assign pix    = latch & {NDOT{awake}};

    // R3: pixel outputs do not move across a falling edge with the strobe low
    a_r3_pix_hold: assert property (@(negedge sclk) disable iff (!rst_n)
        !load_n |=> $stable(pix));

    // R9: a pixel frame edge leaves the configuration words alone
    a_r9_cfg_hold: assert property (@(negedge sclk) disable iff (!rst_n)
        (commit_dot || !load_n) |=> ($stable(cfg0) && $stable(cfg1)));
endmodule

// File: tb/test_dmx_serial_rx.sv
module test_dmx_serial_rx;
    localparam int N  = 160;
    localparam int CW = 7;

    logic sclk    = 1'b0;
    logic rst_n   = 1'b1;
    logic ser_in  = 1'b0;
    logic load_n  = 1'b1;
    logic ctl_sel = 1'b0;

    logic          ser_out;
    logic [N-1:0]  pix;
    logic          asleep;
    logic [CW-1:0] cfg0, cfg1;

    int checks = 0;
    int errors = 0;

    dmx_serial_rx #(.NDOT(N), .CW(CW), .AWAKE_BIT(6)) i_dmx_serial_rx (
        .sclk    (sclk),
        .rst_n   (rst_n),
        .ser_in  (ser_in),
        .load_n  (load_n),
        .ctl_sel (ctl_sel),
        .ser_out (ser_out),
        .pix     (pix),
        .asleep  (asleep),
        .cfg0    (cfg0),
        .cfg1    (cfg1)
    );

    always #4 sclk = ~sclk;

    function automatic logic [N-1:0] make_pat(int kind);
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) begin
            case (kind)
                0:       v[i] = ((i * 13 + 5) % 7) < 3;
                1:       v[i] = ((i * (i + 1) / 2) % 2) == 1;
                default: v[i] = (i % 3) == 0;
            endcase
        end
        return v;
    endfunction

    task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put_bit(logic sel, logic b);
        @(negedge sclk); #2;
        ctl_sel = sel;
        load_n  = 1'b0;
        ser_in  = b;
    endtask

    task automatic end_frame();
        @(negedge sclk); #2;
        load_n = 1'b1;
        @(negedge sclk); #2;
    endtask

    task automatic send_ctl(logic [7:0] v);
        for (int k = 7; k >= 0; k--) put_bit(1'b1, v[k]);
        end_frame();
    endtask

    // Shift a full pixel frame, first bit = position N-1.
    task automatic send_dots(logic [N-1:0] nv, logic [N-1:0] old,
                             logic [N-1:0] shown, bit old_known);
        for (int j = 0; j < N; j++) begin
            put_bit(1'b0, nv[N-1-j]);
            @(posedge sclk); #1;
            if (j == N - 1)
                chk("R7 ser_out after full frame", N'(ser_out), N'(nv[N-1]));
            else if (old_known)
                chk("R7 ser_out delayed chain", N'(ser_out), N'(old[N-2-j]));
            chk("R3 pix held during shifting", pix, shown);
        end
        @(negedge sclk); #2;
        load_n = 1'b1;
        @(posedge sclk); #1;
        chk("R3 pix held before commit edge", pix, shown);
        @(negedge sclk); #2;
    endtask

    initial begin
        logic [N-1:0] pa, pb, pc;
        pa = make_pat(0);
        pb = make_pat(1);
        pc = make_pat(2);

        #1 rst_n = 1'b0;
        repeat (3) @(negedge sclk);
        #2;
        chk("R6 cfg0 cleared by reset", N'(cfg0), '0);
        chk("R6 cfg1 cleared by reset", N'(cfg1), '0);
        chk("R8 asleep after reset", N'(asleep), N'(1'b1));
        chk("R8 pix blank after reset", pix, '0);
        rst_n = 1'b1;

        // First frame while asleep: outputs stay blank.
        send_dots(pa, '0, '0, 1'b0);
        chk("R8 pix blank while asleep", pix, '0);
        chk("R9 cfg0 untouched by pixel frame", N'(cfg0), '0);

        // Wake with brightness code 5 in word 0.
        send_ctl(8'b0100_0101);
        chk("R5 cfg0 written", N'(cfg0), N'(7'h45));
        chk("R5 cfg1 unchanged", N'(cfg1), '0);
        chk("R8 awake after wake bit", N'(asleep), '0);
        chk("R1 pix shows latch", pix, pa);
        chk("R9 chain kept by cfg frame", N'(ser_out), N'(pa[N-1]));

        // Second pattern, old one stays visible until commit.
        send_dots(pb, pa, pa, 1'b1);
        chk("R2 R3 pix shows new frame in order", pix, pb);
        chk("R9 cfg0 kept by pixel frame", N'(cfg0), N'(7'h45));

        // Word 1 write.
        send_ctl({1'b1, 7'h2A});
        chk("R5 cfg1 written", N'(cfg1), N'(7'h2A));
        chk("R5 cfg0 kept when word1 selected", N'(cfg0), N'(7'h45));
        chk("R9 chain kept by word1 frame", N'(ser_out), N'(pb[N-1]));
        chk("R1 pix unchanged by cfg frame", pix, pb);

        // Over-length configuration frame: only the last 8 bits count.
        for (int k = 0; k < 4; k++) put_bit(1'b1, 1'b1);
        begin
            logic [7:0] tail;
            tail = 8'b0100_1101;
            for (int k = 7; k >= 0; k--) put_bit(1'b1, tail[k]);
        end
        end_frame();
        chk("R4 last 8 bits into cfg0", N'(cfg0), N'(7'h4D));
        chk("R4 cfg1 untouched by long frame", N'(cfg1), N'(7'h2A));

        // Sleep then wake.
        send_ctl(8'h03);
        chk("R8 asleep when wake bit clear", N'(asleep), N'(1'b1));
        chk("R8 pix blank when asleep", pix, '0);
        send_ctl(8'h41);
        chk("R8 pix returns on wake", pix, pb);

        // Reset between frames keeps pixel storage.
        rst_n = 1'b0;
        @(negedge sclk); #2;
        chk("R6 cfg0 cleared mid-run", N'(cfg0), '0);
        chk("R6 cfg1 cleared mid-run", N'(cfg1), '0);
        chk("R6 pix blank in reset", pix, '0);
        rst_n = 1'b1;
        send_ctl(8'h47);
        chk("R6 latch survives reset", pix, pb);
        chk("R6 chain survives reset", N'(ser_out), N'(pb[N-1]));

        // Third pattern with full serial-output delay check.
        send_dots(pc, pb, pb, 1'b1);
        chk("R1 third pattern shown", pix, pc);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge sclk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule